// File: doc/BRIEF.md
# Page Write Collector with Timed Commit

This block sits behind a two-wire slave protocol engine inside a small byte-wide nonvolatile storage model. During a write transfer, the engine first reports the word address with a start-of-write strobe. It then hands over each received data byte with a valid strobe. The block holds these bytes in a page latch of `PAGE_BYTES` entries. Each new byte goes to the next slot inside the page. Only the low offset bits of the address advance, so the slot index wraps and the page base never changes.

When the engine signals a stop that ends the write, the block enters a self-timed commit interval lasting `CYCLE_CLKS` system clocks. It raises `busy` for that whole interval. In the first clocks of the interval it issues one array write per slot that was actually filled, in ascending slot order. While `busy` is high the block ignores every input from the protocol engine, so acknowledge polling simply finds it unresponsive.

The block also keeps the current-address pointer that a following address-less read uses. This pointer is updated when the stop arrives.

Top module: `page_commit`

## Requirements
- R1: After reset, `busy` and `arrWe` are 0 and `curAddr` is 0.
- R2: After `wrBegin` with address A, the k-th data byte (k from 0) is committed to the address whose upper `ADDR_W-2` bits equal those of A and whose low 2 bits equal (A[1:0]+k) mod 4. The upper bits never change during a transfer.
- R3: When more than 4 bytes arrive before stop, a later byte that wraps onto an already filled slot replaces it. Only the last value for each slot is committed.
- R4: No array write and no `busy` occur before a stop. `arrWe` is only ever high while `busy` is high.
- R5: When a stop ends a transfer that carried at least one data byte, `busy` rises in the clock after the stop is sampled. It stays high for exactly `CYCLE_CLKS` clocks.
- R6: While `busy` is high, `wrBegin`, `dataValid` and `stopSeen` have no effect. After `busy` falls, the block is idle: a lone stop raises nothing and leaves `curAddr` unchanged.
- R7: A commit writes each filled slot exactly once and no unfilled slot. Writes go out in ascending slot order, one per clock, within the first 4 clocks of `busy`.
- R8: A stop after `wrBegin` with no data byte raises no `busy` and causes no array write. It sets `curAddr` to the word address.
- R9: After a stop that ends a transfer with data, `curAddr` holds the page base joined to (last written offset + 1) mod 4.
- R10: A `wrBegin` that arrives while bytes are still being collected discards the pending bytes and restarts collection at its new address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wrBegin | input | 1 | Start of a write transfer; the word address is on `wrAddr` |
| wrAddr | input | ADDR_W | Word address of the write transfer |
| dataValid | input | 1 | One received data byte is on `dataByte` |
| dataByte | input | DATA_W | Received data byte |
| stopSeen | input | 1 | Valid stop condition that ends the transfer |
| busy | output | 1 | Self-timed commit interval in progress |
| arrWe | output | 1 | Array write strobe |
| arrAddr | output | ADDR_W | Array write address |
| arrData | output | DATA_W | Array write data |
| curAddr | output | ADDR_W | Current-address pointer for the next read |

## Verification
Several behaviours are checked by the embedded assertions on every cycle:
- A commit only ever begins on a stop, and never on a stop after an empty transfer.
- The commit timer ends exactly at its last count.
- Array strobes stay inside `busy`.
- The page latch does not move during a commit.
- Each captured byte advances only the in-page offset.

Other properties only the bench scenarios can show:
- That the wrapped addresses and overwrites land the right bytes in a modelled array.
- That untouched slots keep their old contents.
- That `curAddr` ends at the right wrapped value.
- That random traffic injected during `busy` leaves no trace once the interval ends.

// File: rtl/page_commit_pkg.sv
package page_commit_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic loadBase;  // latch word address, clear fill mask
    logic capture;   // store one data byte at current offset
    logic finish;    // stop seen: update current-address pointer
    logic drain;     // commit phase: present slot slotIdx to the array
  } pgc_ctl_t;
endpackage

// File: rtl/page_commit_ctrl.sv
module page_commit_ctrl
  import page_commit_pkg::*;
#(
  parameter int PAGE_BYTES = 4,
  parameter int CYCLE_CLKS = 500000,
  localparam int OFS_W = $clog2(PAGE_BYTES),
  localparam int CNT_W = $clog2(CYCLE_CLKS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wrBegin,
  input  logic             dataValid,
  input  logic             stopSeen,
  input  logic             anyByte,
  output pgc_ctl_t         ctl,
  output logic [OFS_W-1:0] slotIdx,
  output logic             busy
);
  typedef enum logic [1:0] {S_IDLE, S_COLLECT, S_COMMIT} state_t;

  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(CYCLE_CLKS - 1);
  localparam logic [CNT_W-1:0] PAGE_LIM = CNT_W'(PAGE_BYTES);

  state_t state, nextState;
  logic [CNT_W-1:0] cnt;

  always_comb begin
    ctl = '0;
    nextState = state;
    case (state)
      S_IDLE: begin
        if (wrBegin) begin
          ctl.loadBase = 1'b1;
          nextState = S_COLLECT;
        end
      end
      S_COLLECT: begin
        if (stopSeen) begin
          ctl.finish = 1'b1;
          nextState = anyByte ? S_COMMIT : S_IDLE;
        end else if (wrBegin) begin
          ctl.loadBase = 1'b1;
        end else if (dataValid) begin
          ctl.capture = 1'b1;
        end
      end
      S_COMMIT: begin
        ctl.drain = (cnt < PAGE_LIM);
        if (cnt == LAST_CNT) nextState = S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      cnt   <= '0;
    end else begin
      state <= nextState;
      cnt   <= (state == S_COMMIT && nextState == S_COMMIT) ? cnt + 1'b1 : '0;
    end
  end

  assign busy    = (state == S_COMMIT);
  assign slotIdx = cnt[OFS_W-1:0];

  // R4: a commit interval only begins right after a stop was sampled
  a_r4_commit_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stopSeen));

  // R8: a stop on an empty transfer never starts a commit
  a_r8_empty_no_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_COLLECT && stopSeen && !anyByte) |=> !busy);

  // R5: the interval ends exactly at its last count and not before
  a_r5_ends_on_last: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt == LAST_CNT) |=> !busy);
  a_r5_holds_until_last: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt != LAST_CNT) |=> busy);

  // R6: while busy, no strobe toward the collector is produced
  a_r6_no_capture_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !(ctl.capture || ctl.loadBase || ctl.finish));
endmodule

// File: rtl/page_commit_data.sv
module page_commit_data
  import page_commit_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int PAGE_BYTES = 4,
  localparam int OFS_W = $clog2(PAGE_BYTES),
  localparam int BASE_W = ADDR_W - OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  pgc_ctl_t          ctl,
  input  logic [OFS_W-1:0]  slotIdx,
  input  logic              busyIn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] dataByte,
  output logic              anyByte,
  output logic              arrWe,
  output logic [ADDR_W-1:0] arrAddr,
  output logic [DATA_W-1:0] arrData,
  output logic [ADDR_W-1:0] curAddr
);
  logic [BASE_W-1:0]                  pageBase;
  logic [OFS_W-1:0]                   ofs;
  logic [PAGE_BYTES-1:0]              fillMask;
  logic [PAGE_BYTES-1:0][DATA_W-1:0]  slots;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pageBase <= '0;
      ofs      <= '0;
      fillMask <= '0;
      slots    <= '0;
      curAddr  <= '0;
    end else begin
      if (ctl.loadBase) begin
        pageBase <= wrAddr[ADDR_W-1:OFS_W];
        ofs      <= wrAddr[OFS_W-1:0];
        fillMask <= '0;
      end else if (ctl.capture) begin
        slots[ofs]    <= dataByte;
        fillMask[ofs] <= 1'b1;
        ofs           <= ofs + 1'b1;  // wraps inside the page
      end
      if (ctl.finish) curAddr <= {pageBase, ofs};
    end
  end

  assign anyByte = |fillMask;
  assign arrWe   = ctl.drain && fillMask[slotIdx];
  assign arrAddr = {pageBase, slotIdx};
  assign arrData = slots[slotIdx];

  // R2: each captured byte advances only the in-page offset; base is fixed
  a_r2_offset_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.capture |=> (ofs == $past(ofs) + 1'b1) && $stable(pageBase));

  // R6: page latch frozen throughout a commit interval
  a_r6_latch_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busyIn && $past(busyIn)) |-> ($stable(slots) && $stable(fillMask) && $stable(curAddr)));

  // R4: array strobes only inside the busy interval
  a_r4_we_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    arrWe |-> busyIn);
endmodule

// File: rtl/page_commit.sv
module page_commit
  import page_commit_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int PAGE_BYTES = 4,
  parameter int CYCLE_CLKS = 500000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrBegin,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              dataValid,
  input  logic [DATA_W-1:0] dataByte,
  input  logic              stopSeen,
  output logic              busy,
  output logic              arrWe,
  output logic [ADDR_W-1:0] arrAddr,
  output logic [DATA_W-1:0] arrData,
  output logic [ADDR_W-1:0] curAddr
);
  localparam int OFS_W = $clog2(PAGE_BYTES);

  pgc_ctl_t         ctl;
  logic [OFS_W-1:0] slotIdx;
  logic             anyByte;

  page_commit_ctrl #(.PAGE_BYTES(PAGE_BYTES), .CYCLE_CLKS(CYCLE_CLKS)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .wrBegin(wrBegin), .dataValid(dataValid),
    .stopSeen(stopSeen), .anyByte(anyByte), .ctl(ctl), .slotIdx(slotIdx),
    .busy(busy)
  );

  page_commit_data #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BYTES(PAGE_BYTES)) data_i (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .slotIdx(slotIdx), .busyIn(busy),
    .wrAddr(wrAddr), .dataByte(dataByte), .anyByte(anyByte), .arrWe(arrWe),
    .arrAddr(arrAddr), .arrData(arrData), .curAddr(curAddr)
  );
endmodule

// File: tb/page_commit_tb_top.sv
module page_commit_tb_top;
  localparam int CYC = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wrBegin = 1'b0, dataValid = 1'b0, stopSeen = 1'b0;
  logic [7:0] wrAddr = '0, dataByte = '0;
  logic busy, arrWe;
  logic [7:0] arrAddr, arrData, curAddr;

  int nChk = 0, nBad = 0;
  logic [7:0] tbMem [256];
  logic [7:0] expMem [256];
  logic [7:0] dat [8];

  always #5ns clk = ~clk;

  page_commit #(.ADDR_W(8), .DATA_W(8), .PAGE_BYTES(4), .CYCLE_CLKS(CYC)) dut_i (
    .clk(clk), .rst_n(rst_n), .wrBegin(wrBegin), .wrAddr(wrAddr),
    .dataValid(dataValid), .dataByte(dataByte), .stopSeen(stopSeen),
    .busy(busy), .arrWe(arrWe), .arrAddr(arrAddr), .arrData(arrData),
    .curAddr(curAddr)
  );

  function automatic logic [7:0] slotAddr(logic [7:0] a, int k);
    return {a[7:2], 2'(a[1:0] + k)};
  endfunction

  function automatic logic [7:0] expCur(logic [7:0] a, int n);
    return (n == 0) ? a : slotAddr(a, n);
  endfunction

  task automatic check(string req, logic ok, int act, int exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One complete write transfer; restartAddr >= 0 issues a second wrBegin after 2 bytes (R10)
  task automatic runXfer(logic [7:0] addr, int n, int restartAddr, int n2);
    logic [7:0] a = addr;
    int total, busyCnt, wrCnt, lastSlot, expWr;
    logic preOk = 1'b1, orderOk = 1'b1;
    logic [3:0] used = '0;
    @(negedge clk);
    wrBegin = 1'b1; wrAddr = addr;
    @(negedge clk);
    wrBegin = 1'b0;
    for (int k = 0; k < n; k++) begin
      dataValid = 1'b1; dataByte = dat[k];
      @(negedge clk);
      if (busy || arrWe) preOk = 1'b0;
    end
    total = n;
    if (restartAddr >= 0) begin
      dataValid = 1'b0; wrBegin = 1'b1; a = 8'(restartAddr); wrAddr = a;
      @(negedge clk);
      wrBegin = 1'b0;
      for (int k = 0; k < n2; k++) begin
        dataValid = 1'b1; dataByte = dat[4 + k];
        @(negedge clk);
        if (busy || arrWe) preOk = 1'b0;
      end
      total = n2;
    end
    // expected array contents from the surviving transfer
    for (int k = 0; k < total; k++) begin
      expMem[slotAddr(a, k)] = (restartAddr >= 0) ? dat[4 + k] : dat[k];
      used[slotAddr(a, k) & 8'd3] = 1'b1;
    end
    expWr = $countones(used);
    dataValid = 1'b0; stopSeen = 1'b1;
    @(negedge clk);
    stopSeen = 1'b0;
    check("R4 nothing before stop", preOk, 0, 1);
    busyCnt = 0; wrCnt = 0; lastSlot = -1;
    while (busy && busyCnt < CYC + 5) begin
      if (arrWe) begin
        tbMem[arrAddr] = arrData;
        if (int'(arrAddr[1:0]) <= lastSlot || busyCnt >= 4 || arrAddr[7:2] != a[7:2]) orderOk = 1'b0;
        lastSlot = int'(arrAddr[1:0]);
        wrCnt++;
      end
      busyCnt++;
      wrBegin = 1'($urandom); dataValid = 1'($urandom);
      stopSeen = 1'($urandom); wrAddr = 8'($urandom); dataByte = 8'($urandom);
      @(negedge clk);
    end
    wrBegin = 1'b0; dataValid = 1'b0; stopSeen = 1'b0;
    if (arrWe) orderOk = 1'b0;
    check(total == 0 ? "R8 no busy on empty" : "R5 busy length",
          busyCnt == (total == 0 ? 0 : CYC), busyCnt, total == 0 ? 0 : CYC);
    check("R7 write count", wrCnt == expWr, wrCnt, expWr);
    check("R7 write order", orderOk, 0, 1);
    begin
      int diffs = 0;
      for (int i = 0; i < 256; i++) if (tbMem[i] !== expMem[i]) diffs++;
      check("R2/R3 array contents", diffs == 0, diffs, 0);
    end
    check(total == 0 ? "R8 curAddr" : "R9 curAddr",
          curAddr == expCur(a, total), curAddr, expCur(a, total));
    // R6: after the interval a lone stop must do nothing
    stopSeen = 1'b1;
    @(negedge clk);
    stopSeen = 1'b0;
    check("R6 idle after busy", !busy && curAddr == expCur(a, total),
          {busy, curAddr}, {1'b0, expCur(a, total)});
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 256; i++) begin tbMem[i] = '0; expMem[i] = '0; end
    repeat (3) @(negedge clk);
    check("R1 reset busy", busy == 1'b0, busy, 0);
    check("R1 reset arrWe", arrWe == 1'b0, arrWe, 0);
    check("R1 reset curAddr", curAddr == 8'd0, curAddr, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R2: single byte, then full page from slot 0
    dat[0] = 8'hA5; runXfer(8'h40, 1, -1, 0);
    for (int k = 0; k < 4; k++) dat[k] = 8'(8'h10 + k);
    runXfer(8'h80, 4, -1, 0);
    // R2 wrap: start at slot 3, three bytes wrap to slots 0,1
    for (int k = 0; k < 3; k++) dat[k] = 8'(8'h20 + k);
    runXfer(8'h17, 3, -1, 0);
    // R3: six bytes overwrite the first two slots
    for (int k = 0; k < 6; k++) dat[k] = 8'(8'h30 + k);
    runXfer(8'hFE, 6, -1, 0);
    // R7: partial page keeps untouched slots (one byte into previously filled page)
    dat[0] = 8'h77; runXfer(8'h81, 1, -1, 0);
    // R8: empty transfer
    runXfer(8'h5A, 0, -1, 0);
    // R10: restart discards pending bytes
    dat[0] = 8'hE1; dat[1] = 8'hE2; dat[4] = 8'hC3;
    runXfer(8'h60, 2, 8'h92, 1);
    // random transfers
    for (int t = 0; t < 25; t++) begin
      int n = int'($urandom_range(0, 7));
      for (int k = 0; k < 8; k++) dat[k] = 8'($urandom);
      runXfer(8'($urandom), n, -1, 0);
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    #(200000 * 10ns);
    nChk++; nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule